// File: doc/BRIEF.md
# Programmable Chip-Select Address Decoder

This block turns a 24-bit bus address into one of four chip-select strobes. When no enabled area claims the access, it raises a default-area flag instead. Each area has two eight-bit registers, a start register and a mask register. The start register holds address lines 23..16. A start bit below line 16 is taken as zero.

Mask granularity is not the same in every area. In area 0 and area 1, one mask bit controls a whole run of middle address lines. In area 2 and area 3, the mask covers only upper lines, one bit per line. A control register holds an enable bit for each area and a mode bit for area 2.

Out of reset, only area 2 is enabled, and its mode bit leaves it matching the whole address space. A bus controller drives the address together with a cycle-valid strobe. It uses the chip-select to choose a device. It uses the default flag to fall back to its default width and wait settings. A small synchronous register port lets software program the decoder and read back its configuration.

Top module: `cs_decoder`

## Requirements
- R1: After reset, every start and mask register reads FFh, and the control register reads 04h. Register select 0..3 is the start register of areas 0..3, select 4..7 is the mask register of areas 0..3, and select 8 is the control register. Read data is registered and appears one clock after the select is presented.
- R2: Control bit n (n = 0..3) enables area n, and control bit 4 is the area-2 decode mode. While area 2 is enabled with mode 0, area 2 matches every address regardless of its start and mask registers.
- R3: While bus_valid is low, every chip-select output and the default flag are low.
- R4: Area 0 mask bits 7..2 each exclude one of the lines A20..A15, with bit 7 standing for A20. Mask bit 1 excludes A14..A9 together, and mask bit 0 excludes A8. A mask bit of 0 means the line takes part in the comparison.
- R5: Area 1 mask bits 7..2 each exclude one of the lines A21..A16, with bit 7 standing for A21. Mask bit 1 excludes A15..A9 together, and mask bit 0 excludes A8.
- R6: Area 2 and area 3 mask bits 7..0 each exclude one of the lines A22..A15, with bit 7 standing for A22. Area 2 uses this rule when its mode bit is 1.
- R7: In every area, address lines above the masked range are always compared, and lines below it are never compared. Each compared line is checked against the start register, and any line below A16 is checked against 0.
- R8: With bus_valid high, exactly one output is high: a chip-select, or the default flag when no enabled area matches.
- R9: When several enabled areas match, the lowest-numbered area wins. A disabled area never asserts its chip-select.
- R10: A register write takes effect on the clock edge that samples it, and the outputs reflect it straight after that edge. A write to an unmapped select (9..15) changes nothing. Unmapped selects, and control bits 7..5, read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register select for write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data for the previous cycle's select |
| bus_valid | input | 1 | Bus cycle valid |
| bus_addr | input | 24 | Bus address |
| cs_o | output | 4 | Chip-select per area, active high |
| dflt_o | output | 1 | No enabled area matched a valid cycle |

## Verification
Each mask layout is probed with addresses one line inside and one line outside the compared range:
- Setting and clearing the single ganged bit in areas 0 and 1 shows whether it governs the full run.
- Toggling a neighbouring individual bit shows that the run stays separate from it.
- For area 1 and area 3, addresses that differ only in A22 or A23 separate "always compared" from "masked".
- Overlapping configurations of all four areas check the priority order.
- Disabling areas one at a time checks that the default flag takes over.

A pseudo-random address sweep then runs against a behavioural line-by-line model.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int ADDR_W  = 24;
  localparam int REG_W   = 8;
  localparam int N_AREA  = 4;
  localparam int SEL_W   = 4;

  // how an area's mask byte maps onto address lines
  typedef enum logic [1:0] {
    KIND_GANG_A0 = 2'd0,  // individual 20..15, run 14..9, single 8
    KIND_GANG_A1 = 2'd1,  // individual 21..16, run 15..9, single 8
    KIND_UPPER   = 2'd2   // individual 22..15
  } mask_kind_e;

  function automatic mask_kind_e kind_of(input int idx);
    if (idx == 0) return KIND_GANG_A0;
    if (idx == 1) return KIND_GANG_A1;
    return KIND_UPPER;
  endfunction
endpackage

// File: rtl/cs_cfg_regs.sv
module cs_cfg_regs
  import cs_pkg::*;
#(
  parameter int NA  = N_AREA,
  parameter int RW  = REG_W,
  parameter int SW  = SEL_W,
  parameter int WHOLE_AREA = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [SW-1:0]          sel,
  input  logic [RW-1:0]          wdata,
  output logic [RW-1:0]          rdata,
  output logic [NA-1:0][RW-1:0]  start_o,
  output logic [NA-1:0][RW-1:0]  mask_o,
  output logic [NA-1:0]          en_o,
  output logic                   whole_mode_o
);
  localparam int CTRL_SEL = 2 * NA;
  localparam int CTRL_W   = NA + 1;
  localparam logic [CTRL_W-1:0] CTRL_RST = CTRL_W'(1) << WHOLE_AREA;

  logic [NA-1:0][RW-1:0] start_q, mask_q;
  logic [CTRL_W-1:0]     ctrl_q;
  logic [RW-1:0]         rd_mux, rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '1;
      mask_q  <= '1;
      ctrl_q  <= CTRL_RST;
    end else if (we) begin
      for (int i = 0; i < NA; i++) begin
        if (sel == SW'(i))      start_q[i] <= wdata;
        if (sel == SW'(NA + i)) mask_q[i]  <= wdata;
      end
      if (sel == SW'(CTRL_SEL)) ctrl_q <= wdata[CTRL_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NA; i++) begin
      if (sel == SW'(i))      rd_mux = start_q[i];
      if (sel == SW'(NA + i)) rd_mux = mask_q[i];
    end
    if (sel == SW'(CTRL_SEL)) rd_mux = RW'(ctrl_q);
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end

  assign rdata        = rdata_q;
  assign start_o      = start_q;
  assign mask_o       = mask_q;
  assign en_o         = ctrl_q[NA-1:0];
  assign whole_mode_o = ~ctrl_q[NA];

  // R10: a write to start register 0 is visible after the edge
  p_start_write_r10: assert property (@(posedge clk) disable iff (rst)
    (we && sel == SW'(0)) |=> (start_o[0] == $past(wdata)));

  // R10: unmapped selects leave the enables alone
  p_unmapped_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (we && sel > SW'(CTRL_SEL)) |=> $stable(en_o));
endmodule

// File: rtl/cs_area_match.sv
module cs_area_match
  import cs_pkg::*;
#(
  parameter int         AW   = ADDR_W,
  parameter int         RW   = REG_W,
  parameter mask_kind_e KIND = KIND_UPPER
) (
  input  logic [AW-1:0] addr,
  input  logic [RW-1:0] start,
  input  logic [RW-1:0] mask,
  input  logic          en,
  input  logic          whole,
  output logic          hit
);
  localparam int START_LO = AW - RW;
  localparam int TOP_LINE = (KIND == KIND_GANG_A0) ? 20 :
                            (KIND == KIND_GANG_A1) ? 21 : 22;
  localparam int RUN_HI   = (KIND == KIND_GANG_A0) ? 14 : 15;
  localparam int RUN_LO   = 9;
  localparam int SOLO_LO  = 8;
  localparam int UP_LO    = 15;

  logic [AW-1:0] care;
  logic [AW-1:0] ref_addr;

  assign ref_addr = {start, {START_LO{1'b0}}};

  generate
    if (KIND == KIND_UPPER) begin : g_upper
      always_comb begin
        care = '0;
        for (int l = 0; l < AW; l++) begin
          if (l > TOP_LINE)   care[l] = 1'b1;
          else if (l >= UP_LO) care[l] = ~mask[l - UP_LO];
        end
      end
    end else begin : g_gang
      always_comb begin
        care = '0;
        for (int l = 0; l < AW; l++) begin
          if (l > TOP_LINE)      care[l] = 1'b1;
          else if (l > RUN_HI)   care[l] = ~mask[l - RUN_HI + 1];
          else if (l >= RUN_LO)  care[l] = ~mask[1];
          else if (l == SOLO_LO) care[l] = ~mask[0];
        end
      end
    end
  endgenerate

  assign hit = en & (whole | ~|((addr ^ ref_addr) & care));
endmodule

// File: rtl/cs_decoder.sv
module cs_decoder
  import cs_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int RW = REG_W,
  parameter int NA = N_AREA,
  parameter int SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [SW-1:0] reg_sel,
  input  logic [RW-1:0] reg_wdata,
  output logic [RW-1:0] reg_rdata,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  output logic [NA-1:0] cs_o,
  output logic          dflt_o
);
  localparam int WHOLE_AREA = 2;

  logic [NA-1:0][RW-1:0] start_w, mask_w;
  logic [NA-1:0]         en_w, hit_w;
  logic                  whole_w;

  cs_cfg_regs #(.NA(NA), .RW(RW), .SW(SW), .WHOLE_AREA(WHOLE_AREA)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .rdata(reg_rdata), .start_o(start_w), .mask_o(mask_w), .en_o(en_w),
    .whole_mode_o(whole_w)
  );

  for (genvar i = 0; i < NA; i++) begin : g_area
    cs_area_match #(.AW(AW), .RW(RW), .KIND(kind_of(i))) u_match (
      .addr(bus_addr), .start(start_w[i]), .mask(mask_w[i]), .en(en_w[i]),
      .whole((i == WHOLE_AREA) ? whole_w : 1'b0), .hit(hit_w[i])
    );

    // R9: a disabled area stays quiet
    p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (rst)
      !en_w[i] |-> !cs_o[i]);
  end

  always_comb begin
    logic taken;
    taken = 1'b0;
    cs_o  = '0;
    for (int i = 0; i < NA; i++) begin
      cs_o[i] = bus_valid & hit_w[i] & ~taken;
      taken   = taken | hit_w[i];
    end
    dflt_o = bus_valid & ~taken;
  end

  // R9: at most one chip-select at a time
  p_cs_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cs_o));

  // R8: a valid cycle has exactly one outcome
  p_one_outcome_r8: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> ($countones({cs_o, dflt_o}) == 1));

  // R3: nothing asserts outside a bus cycle
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |-> (cs_o == '0 && !dflt_o));

  // R2: whole-space mode makes area 2 match anything
  p_area2_whole_r2: assert property (@(posedge clk) disable iff (rst)
    (en_w[WHOLE_AREA] && whole_w) |-> hit_w[WHOLE_AREA]);
endmodule

// File: tb/test_cs_decoder.sv
module test_cs_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_sel = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        bus_valid = 1'b0;
  logic [23:0] bus_addr = '0;
  logic [3:0]  cs_o;
  logic        dflt_o;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  logic [7:0] m_start [4];
  logic [7:0] m_mask  [4];
  logic [7:0] m_ctrl;

  cs_decoder i_cs_decoder (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
    .bus_addr(bus_addr), .cs_o(cs_o), .dflt_o(dflt_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // -1: always compared, -2: never compared, else the mask bit index
  function automatic int line_code(int area, int line);
    case (area)
      0: begin
        if (line >= 21) return -1;
        if (line >= 15) return line - 13;
        if (line >= 9)  return 1;
        if (line == 8)  return 0;
        return -2;
      end
      1: begin
        if (line >= 22) return -1;
        if (line >= 16) return line - 14;
        if (line >= 9)  return 1;
        if (line == 8)  return 0;
        return -2;
      end
      default: begin
        if (line == 23) return -1;
        if (line >= 15) return line - 15;
        return -2;
      end
    endcase
  endfunction

  function automatic bit ref_hit(int area, logic [23:0] a);
    if (!m_ctrl[area]) return 0;
    if (area == 2 && !m_ctrl[4]) return 1;
    for (int l = 0; l < 24; l++) begin
      int c;
      bit sb;
      c = line_code(area, l);
      sb = (l >= 16) ? m_start[area][l-16] : 1'b0;
      if ((c == -1 || (c >= 0 && !m_mask[area][c])) && a[l] != sb) return 0;
    end
    return 1;
  endfunction

  function automatic logic [7:0] ref_read(logic [3:0] s);
    if (s < 4) return m_start[s];
    if (s < 8) return m_mask[s-4];
    if (s == 8) return m_ctrl & 8'h1F;
    return 8'h00;
  endfunction

  task automatic check(string tag, logic [7:0] exp_rd, bit chk_rd);
    logic [3:0] exp_cs;
    logic       exp_df;
    exp_cs = '0;
    exp_df = 1'b0;
    if (bus_valid) begin
      exp_df = 1'b1;
      for (int i = 0; i < 4; i++)
        if (exp_df && ref_hit(i, bus_addr)) begin
          exp_cs[i] = 1'b1;
          exp_df = 1'b0;
        end
    end
    vectors++;
    if (cs_o !== exp_cs || dflt_o !== exp_df || (chk_rd && reg_rdata !== exp_rd)) begin
      errors++;
      $display("FAIL %s addr=%h cs=%b dflt=%b rd=%h expected cs=%b dflt=%b rd=%h",
               tag, bus_addr, cs_o, dflt_o, reg_rdata, exp_cs, exp_df, exp_rd);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(string tag, bit we, logic [3:0] s, logic [7:0] d,
                      bit v, logic [23:0] a);
    logic [7:0] exp_rd;
    reg_we = we; reg_sel = s; reg_wdata = d; bus_valid = v; bus_addr = a;
    exp_rd = ref_read(s);
    if (we) begin
      if (s < 4) m_start[s] = d;
      else if (s < 8) m_mask[s-4] = d;
      else if (s == 8) m_ctrl = d & 8'h1F;
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, exp_rd, 1);
  endtask

  task automatic wr(string tag, logic [3:0] s, logic [7:0] d);
    step(tag, 1, s, d, 0, 24'h0);
  endtask

  task automatic probe(string tag, logic [23:0] a);
    step(tag, 0, 4'd8, 8'h00, 1, a);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin m_start[i] = 8'hFF; m_mask[i] = 8'hFF; end
    m_ctrl = 8'h04;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1", 8'h00, 1);
    // R1: reset values by readback
    for (int s = 0; s < 9; s++) step("R1", 0, 4'(s), 8'h00, 0, 24'h0);
    step("R1", 0, 4'd0, 8'h00, 0, 24'h0);
    // R2: reset area 2 covers the whole space
    probe("R2", 24'h000000);
    probe("R2", 24'hFFFFFF);
    probe("R2", 24'h5A3C01);
    // R3: idle cycles
    step("R3", 0, 4'd0, 8'h00, 0, 24'h123456);
    // R4: area 0
    wr("R4", 4'd0, 8'h12);
    wr("R4", 4'd4, 8'h00);
    wr("R4", 4'd8, 8'h05);
    probe("R4", 24'h1200AB);
    probe("R4", 24'h1201AB);
    wr("R4", 4'd4, 8'h01);
    probe("R4", 24'h1201AB);
    probe("R4", 24'h120200);
    wr("R4", 4'd4, 8'h03);
    probe("R4", 24'h127E00);
    probe("R4", 24'h128000);
    wr("R4", 4'd4, 8'h07);
    probe("R4", 24'h12FFFF);
    probe("R4", 24'h13FFFF);
    // R5: area 1
    wr("R5", 4'd8, 8'h03);
    wr("R5", 4'd1, 8'h34);
    wr("R5", 4'd5, 8'h02);
    probe("R5", 24'h34FE00);
    probe("R5", 24'h34FF00);
    probe("R5", 24'h3500FF);
    // R7: A22 and A23 always compared in area 1
    wr("R7", 4'd1, 8'h00);
    wr("R7", 4'd5, 8'hFF);
    probe("R7", 24'h3FFFFF);
    probe("R7", 24'h400000);
    probe("R7", 24'h800000);
    // R6: area 3 and area 2 in decode mode
    wr("R6", 4'd8, 8'h18);
    wr("R6", 4'd3, 8'h80);
    wr("R6", 4'd7, 8'h7F);
    probe("R6", 24'h807FFF);
    probe("R6", 24'h808000);
    probe("R6", 24'h7F0000);
    wr("R6", 4'd7, 8'hFE);
    probe("R6", 24'hFF8000);
    probe("R6", 24'hFE8000);
    wr("R6", 4'd8, 8'h14);
    wr("R6", 4'd2, 8'hA0);
    wr("R6", 4'd6, 8'h00);
    probe("R6", 24'hA00000);
    probe("R6", 24'hA07FFF);
    probe("R6", 24'hA08000);
    // R9: overlap priority
    for (int i = 0; i < 4; i++) begin wr("R9", 4'(i), 8'h40); wr("R9", 4'(4+i), 8'hFF); end
    wr("R9", 4'd8, 8'h0F);
    probe("R9", 24'h40ABCD);
    wr("R9", 4'd8, 8'h0E);
    probe("R9", 24'h40ABCD);
    wr("R9", 4'd8, 8'h0C);
    probe("R9", 24'h40ABCD);
    wr("R9", 4'd8, 8'h08);
    probe("R9", 24'h40ABCD);
    // R8: default area when nothing matches
    wr("R8", 4'd8, 8'h00);
    probe("R8", 24'h40ABCD);
    wr("R8", 4'd8, 8'h1B);
    probe("R8", 24'hC00000);
    // R10: unmapped write ignored, unused bits read zero
    wr("R10", 4'd9, 8'h00);
    wr("R10", 4'd15, 8'h00);
    step("R10", 0, 4'd9, 8'h00, 1, 24'h400000);
    step("R10", 0, 4'd8, 8'h00, 1, 24'h400000);
    wr("R10", 4'd8, 8'hE1);
    step("R10", 0, 4'd8, 8'h00, 1, 24'h400000);
    step("R10", 0, 4'd0, 8'h00, 1, 24'h400000);
    // R8: sweep with mixed configuration
    wr("R8", 4'd0, 8'h12); wr("R8", 4'd4, 8'h03);
    wr("R8", 4'd1, 8'h34); wr("R8", 4'd5, 8'h0E);
    wr("R8", 4'd2, 8'h80); wr("R8", 4'd6, 8'h3C);
    wr("R8", 4'd3, 8'h00); wr("R8", 4'd7, 8'hFF);
    wr("R8", 4'd8, 8'h1B);
    begin
      logic [23:0] lfsr;
      lfsr = 24'hACE1F3;
      for (int k = 0; k < 400; k++) begin
        lfsr = {lfsr[22:0], lfsr[23] ^ lfsr[22] ^ lfsr[21] ^ lfsr[16]};
        probe("R8", (k % 3 == 0) ? {8'h12, lfsr[15:0]} : lfsr);
      end
    end
    done = 1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule